// File: doc/BRIEF.md
# Column-Streaming Block Distortion Array

This block computes the sum of absolute differences (SAD) between one N×N block of current-picture pixels and a series of candidate blocks in a reference picture. The candidates lie in vertical search columns. The current block is written once, row by row, into registers inside a grid of processing elements, and it stays there for the whole search. After that, reference data arrives one N-pixel row per cycle. Every PE row receives that row at the same time. Each PE row forms its N absolute differences and reduces them with a one-dimensional adder tree. The resulting row sums move downward through a chain of propagation registers, and the last stage holds the finished block SAD.

Reference rows for even search columns arrive on one port, and rows for odd columns arrive on the other. Because of this split, the first rows of the next column can enter while the last candidates of the current column are still in the chain. After the start-up latency, the array therefore produces one SAD per cycle across column boundaries. Each result carries the column number and the vertical offset of its candidate. Picking the best vector and generating addresses into the search window are done elsewhere.

Top module: `sad_column_array`

## Requirements
- R1: While rst_n is low, and after its release until a candidate completes, out_valid is 0.
- R2: out_sad equals the sum over i,j in 0..N-1 of |C[i][j] - F[v+i][j]|. Here C[i] is the current row written with cur_row = i, F[r] is row r of the candidate's column, and pixel j occupies bits 8j+7..8j of cur_pix and of both reference inputs.
- R3: The result for vertical offset v is registered on the same clock edge that samples row v+N-1 of its column. out_valid is high for exactly the cycle after that edge.
- R4: A column of ROWS rows given on consecutive cycles yields ROWS-N+1 results on consecutive cycles, with out_vofs running 0 to ROWS-N.
- R5: Port A carries columns 0, 2, 4 and so on, and port B carries columns 1, 3 and so on. A port moves to its next column after ROWS valid rows. The rows of one column arrive on consecutive cycles.
- R6: out_col and out_vofs give the column number and the vertical offset of the candidate behind out_sad.
- R7: The next column may start on the other port in the cycle after row ROWS-N of the current column. Results then continue with no idle cycle, while both ports are valid together for N-1 cycles.
- R8: While cur_we is 0, cur_row and cur_pix have no effect on the stored block. This is visible in later SAD values.
- R9: In any cycle that follows an edge at which no candidate completed, out_valid is 0. This covers gaps between columns.
- R10: out_sad is 8+2·log2(N) bits wide. An all-255 current block against an all-zero reference gives exactly N·N·255, and identical data gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_we | input | 1 | Write enable for one current-block row |
| cur_row | input | log2(N) | Index of the current row being written |
| cur_pix | input | 8·N | Current-row pixels, pixel j at bits 8j+7..8j |
| ref_a_valid | input | 1 | Port A row valid (even columns) |
| ref_a_pix | input | 8·N | Port A reference row |
| ref_b_valid | input | 1 | Port B row valid (odd columns) |
| ref_b_pix | input | 8·N | Port B reference row |
| out_valid | output | 1 | SAD result valid |
| out_sad | output | 8+2·log2(N) | Block SAD |
| out_col | output | COL_W | Search column of the result |
| out_vofs | output | log2(ROWS) | Vertical offset of the result |

## Verification
The stimulus patterns are chosen so that each one exposes a different kind of fault:
- **Hashed pixels:** a single column of hashed pixel data checks the pixel pairing and each row's delay. A pixel-lane swap or a row misalignment gives a wrong sum at some offset.
- **Back-to-back columns:** four gapless columns that alternate between the ports test the port selection for each stage during the N-1 overlap cycles. A stage that takes the wrong port corrupts exactly the candidates that straddle a column boundary.
- **Idle gaps:** columns separated by idle gaps check that no stray result appears.
- **Extreme data:** all-255 against all-zero data, and all-zero against all-zero data, check the top of the sum width and the zero case.
- **Ignored writes:** writes held off by a low cur_we are followed by a search. The search shows whether the stored block leaked.

// File: rtl/sad_array_pkg.sv
`timescale 1ns/1ps
package sad_array_pkg;
  typedef logic [7:0] pix_t;

  function automatic logic [7:0] abs_diff(input pix_t a, input pix_t b);
    return (a > b) ? (a - b) : (b - a);
  endfunction
endpackage

// File: rtl/sad_row_pe.sv
`timescale 1ns/1ps
// One PE row: keeps one current-block row, forms N absolute differences
// against the broadcast reference row and reduces them in a binary tree.
module sad_row_pe #(
  parameter int N = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_en,
  input  logic [N*8-1:0]            load_pix,
  input  logic [N*8-1:0]            ref_pix,
  output logic [8+$clog2(N)-1:0]    row_sad
);
  import sad_array_pkg::*;
  localparam int ROW_W = 8 + $clog2(N);
  localparam int NODES = 2 * N - 1;

  logic [N*8-1:0] cur_q;
  logic [N*8-1:0] cur_d;

  always_comb begin
    cur_d = cur_q;
    if (load_en) cur_d = load_pix;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= cur_d;
  end

  // heap-ordered tree: leaves at N-1 .. 2N-2, root at 0
  logic [ROW_W-1:0] node [NODES];

  genvar j, k;
  generate
    for (j = 0; j < N; j++) begin : g_leaf
      assign node[N-1+j] = ROW_W'(abs_diff(cur_q[8*j +: 8], ref_pix[8*j +: 8]));
    end
    for (k = 0; k < N - 1; k++) begin : g_add
      assign node[k] = node[2*k+1] + node[2*k+2];
    end
  endgenerate

  assign row_sad = node[0];
endmodule

// File: rtl/ref_port_track.sv
`timescale 1ns/1ps
// Per-port row and column bookkeeping. A candidate starts on every row whose
// index still leaves N rows in the column.
module ref_port_track #(
  parameter int ROWS   = 8,
  parameter int CANDS  = 5,
  parameter int COL_W  = 6,
  parameter int PARITY = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       start,
  output logic [$clog2(ROWS)-1:0]    vofs,
  output logic [COL_W-1:0]           col
);
  localparam int VW = $clog2(ROWS);

  logic [VW-1:0]    row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;

  always_comb begin
    row_d = row_q;
    col_d = col_q;
    if (in_valid) begin
      if (row_q == VW'(ROWS - 1)) begin
        row_d = '0;
        col_d = col_q + COL_W'(2);
      end else begin
        row_d = row_q + VW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= COL_W'(PARITY);
    end else begin
      row_q <= row_d;
      col_q <= col_d;
    end
  end

  assign start = in_valid && (row_q < VW'(CANDS));
  assign vofs  = row_q;
  assign col   = col_q;
endmodule

// File: rtl/sad_stage.sv
`timescale 1ns/1ps
// Propagation register of one PE row: adds that row's distortion to the
// partial SAD arriving from above and carries the candidate tag along.
module sad_stage #(
  parameter int SAD_W = 12,
  parameter int ROW_W = 10,
  parameter int COL_W = 6,
  parameter int VW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [COL_W-1:0] in_col,
  input  logic [VW-1:0]    in_vofs,
  input  logic [SAD_W-1:0] in_psum,
  input  logic [ROW_W-1:0] row_sad,
  output logic             out_vld,
  output logic [COL_W-1:0] out_col,
  output logic [VW-1:0]    out_vofs,
  output logic [SAD_W-1:0] out_psum
);
  logic             vld_d;
  logic [COL_W-1:0] col_d;
  logic [VW-1:0]    vofs_d;
  logic [SAD_W-1:0] sum_d;

  always_comb begin
    vld_d  = in_vld;
    col_d  = out_col;
    vofs_d = out_vofs;
    sum_d  = out_psum;
    if (in_vld) begin
      col_d  = in_col;
      vofs_d = in_vofs;
      sum_d  = in_psum + SAD_W'(row_sad);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_col  <= '0;
      out_vofs <= '0;
      out_psum <= '0;
    end else begin
      out_vld  <= vld_d;
      out_col  <= col_d;
      out_vofs <= vofs_d;
      out_psum <= sum_d;
    end
  end
endmodule

// File: rtl/sad_column_array.sv
`timescale 1ns/1ps
module sad_column_array #(
  parameter int N     = 4,
  parameter int ROWS  = 8,
  parameter int COL_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cur_we,
  input  logic [$clog2(N)-1:0]       cur_row,
  input  logic [N*8-1:0]             cur_pix,
  input  logic                       ref_a_valid,
  input  logic [N*8-1:0]             ref_a_pix,
  input  logic                       ref_b_valid,
  input  logic [N*8-1:0]             ref_b_pix,
  output logic                       out_valid,
  output logic [8+2*$clog2(N)-1:0]   out_sad,
  output logic [COL_W-1:0]           out_col,
  output logic [$clog2(ROWS)-1:0]    out_vofs
);
  localparam int LG    = $clog2(N);
  localparam int ROW_W = 8 + LG;
  localparam int SAD_W = 8 + 2 * LG;
  localparam int VW    = $clog2(ROWS);
  localparam int CANDS = ROWS - N + 1;

  // port trackers: index 0 = port A (even columns), 1 = port B (odd)
  logic [1:0]       trk_valid;
  logic [1:0]       trk_start;
  logic [VW-1:0]    trk_vofs [2];
  logic [COL_W-1:0] trk_col  [2];

  assign trk_valid = {ref_b_valid, ref_a_valid};

  genvar p;
  generate
    for (p = 0; p < 2; p++) begin : g_port
      ref_port_track #(
        .ROWS(ROWS), .CANDS(CANDS), .COL_W(COL_W), .PARITY(p)
      ) u_trk (
        .clk(clk), .rst_n(rst_n), .in_valid(trk_valid[p]),
        .start(trk_start[p]), .vofs(trk_vofs[p]), .col(trk_col[p])
      );
    end
  endgenerate

  logic start_a, start_b;
  assign start_a = trk_start[0];
  assign start_b = trk_start[1] && !trk_start[0];

  // stage inputs and registered stage outputs
  logic             st_in_vld  [N];
  logic [COL_W-1:0] st_in_col  [N];
  logic [VW-1:0]    st_in_vofs [N];
  logic [SAD_W-1:0] st_in_psum [N];
  logic             st_vld     [N];
  logic [COL_W-1:0] st_col     [N];
  logic [VW-1:0]    st_vofs    [N];
  logic [SAD_W-1:0] st_psum    [N];
  logic [N*8-1:0]   pe_ref     [N];
  logic [ROW_W-1:0] pe_sad     [N];
  logic [N-1:0]     pe_load;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_row
      if (i == 0) begin : g_head
        assign st_in_vld[i]  = start_a || start_b;
        assign st_in_col[i]  = start_b ? trk_col[1]  : trk_col[0];
        assign st_in_vofs[i] = start_b ? trk_vofs[1] : trk_vofs[0];
        assign st_in_psum[i] = '0;
      end else begin : g_chain
        assign st_in_vld[i]  = st_vld[i-1];
        assign st_in_col[i]  = st_col[i-1];
        assign st_in_vofs[i] = st_vofs[i-1];
        assign st_in_psum[i] = st_psum[i-1];
      end

      // column parity picks the port the candidate in this stage reads
      assign pe_ref[i]  = st_in_col[i][0] ? ref_b_pix : ref_a_pix;
      assign pe_load[i] = cur_we && (cur_row == LG'(i));

      sad_row_pe #(.N(N)) u_pe (
        .clk(clk), .rst_n(rst_n), .load_en(pe_load[i]),
        .load_pix(cur_pix), .ref_pix(pe_ref[i]), .row_sad(pe_sad[i])
      );

      sad_stage #(
        .SAD_W(SAD_W), .ROW_W(ROW_W), .COL_W(COL_W), .VW(VW)
      ) u_st (
        .clk(clk), .rst_n(rst_n),
        .in_vld(st_in_vld[i]), .in_col(st_in_col[i]),
        .in_vofs(st_in_vofs[i]), .in_psum(st_in_psum[i]),
        .row_sad(pe_sad[i]),
        .out_vld(st_vld[i]), .out_col(st_col[i]),
        .out_vofs(st_vofs[i]), .out_psum(st_psum[i])
      );
    end
  endgenerate

  assign out_valid = st_vld[N-1];
  assign out_sad   = st_psum[N-1];
  assign out_col   = st_col[N-1];
  assign out_vofs  = st_vofs[N-1];
endmodule

// File: rtl/sad_column_array_chk.sv
`timescale 1ns/1ps
module sad_column_array_chk #(
  parameter int N     = 4,
  parameter int ROWS  = 8,
  parameter int COL_W = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ref_a_valid,
  input logic                       ref_b_valid,
  input logic                       out_valid,
  input logic [8+2*$clog2(N)-1:0]   out_sad,
  input logic [COL_W-1:0]           out_col,
  input logic [$clog2(ROWS)-1:0]    out_vofs
);
  localparam int VW = $clog2(ROWS);
  localparam int SW = 8 + 2 * $clog2(N);
  localparam logic [SW:0] MAX_SAD = (SW+1)'(N * N * 255);
  localparam logic [VW-1:0] LAST_VOFS = VW'(ROWS - N);

  a_r10_sad_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, out_sad} <= MAX_SAD));

  a_r4_vofs_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_vofs <= LAST_VOFS));

  a_r4_vofs_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid) && (out_col == $past(out_col)))
      |-> (out_vofs == $past(out_vofs) + VW'(1)));

  a_r5_even_port_a: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_col[0]) |-> $past(ref_a_valid));

  a_r5_odd_port_b: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_col[0]) |-> $past(ref_b_valid));

  a_r9_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(ref_a_valid || ref_b_valid));
endmodule

bind sad_column_array sad_column_array_chk #(.N(N), .ROWS(ROWS), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_a_valid(ref_a_valid), .ref_b_valid(ref_b_valid),
  .out_valid(out_valid), .out_sad(out_sad), .out_col(out_col), .out_vofs(out_vofs)
);

// File: tb/tb_sad_column_array.sv
`timescale 1ns/1ps
module tb_sad_column_array;
  localparam int N     = 4;
  localparam int ROWS  = 8;
  localparam int COL_W = 6;
  localparam int LG    = $clog2(N);
  localparam int SAD_W = 8 + 2 * LG;
  localparam int VW    = $clog2(ROWS);
  localparam int CANDS = ROWS - N + 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 rst_n;
  logic                 cur_we;
  logic [LG-1:0]        cur_row;
  logic [N*8-1:0]       cur_pix;
  logic                 ref_a_valid, ref_b_valid;
  logic [N*8-1:0]       ref_a_pix, ref_b_pix;
  logic                 out_valid;
  logic [SAD_W-1:0]     out_sad;
  logic [COL_W-1:0]     out_col;
  logic [VW-1:0]        out_vofs;

  sad_column_array #(.N(N), .ROWS(ROWS), .COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .cur_we(cur_we), .cur_row(cur_row), .cur_pix(cur_pix),
    .ref_a_valid(ref_a_valid), .ref_a_pix(ref_a_pix),
    .ref_b_valid(ref_b_valid), .ref_b_pix(ref_b_pix),
    .out_valid(out_valid), .out_sad(out_sad), .out_col(out_col), .out_vofs(out_vofs)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int cur_m [N][N];
  int ref_mode;
  int e_sad [int];
  int e_col [int];
  int e_vofs [int];

  task automatic check(string req, bit ok, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cpix(int mode, int seed, int i, int j);
    if (mode == 1) return 255;
    if (mode == 2) return 0;
    return (seed * 37 + i * 53 + j * 101 + i * j * 7 + 11) % 256;
  endfunction

  function automatic int rpix(int c, int r, int j);
    if (ref_mode == 1) return 0;
    return (c * 71 + r * 29 + j * 13 + c * r * 5 + r * j * 3 + 90) % 256;
  endfunction

  task automatic idle_inputs();
    cur_we = 0; cur_row = '0; cur_pix = '0;
    ref_a_valid = 0; ref_b_valid = 0; ref_a_pix = '0; ref_b_pix = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1 out_valid during reset", out_valid == 1'b0, out_valid, 0);
    rst_n = 1;
  endtask

  task automatic load_block(int mode, int seed);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      cur_we = 1; cur_row = LG'(i);
      for (int j = 0; j < N; j++) begin
        cur_m[i][j] = cpix(mode, seed, i, j);
        cur_pix[8*j +: 8] = 8'(cur_m[i][j]);
      end
    end
    @(negedge clk);
    cur_we = 0;
  endtask

  // drive ncols columns, column c on port c%2, spaced CANDS+gap cycles apart
  task automatic run_cols(string tag, int ncols, int gap);
    int st [16];
    int total, seen;
    e_sad.delete(); e_col.delete(); e_vofs.delete();
    for (int c = 0; c < ncols; c++) st[c] = c * (CANDS + gap);
    total = st[ncols-1] + ROWS + N + 2;
    for (int c = 0; c < ncols; c++)
      for (int v = 0; v < CANDS; v++) begin
        int s = 0;
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++) begin
            int d = cur_m[i][j] - rpix(c, v + i, j);
            s += (d < 0) ? -d : d;
          end
        e_sad[st[c] + v + N - 1]  = s;
        e_col[st[c] + v + N - 1]  = c;
        e_vofs[st[c] + v + N - 1] = v;
      end
    seen = 0;
    for (int t = 0; t < total; t++) begin
      @(negedge clk);
      ref_a_valid = 0; ref_b_valid = 0;
      for (int c = 0; c < ncols; c++)
        if (t >= st[c] && t < st[c] + ROWS) begin
          for (int j = 0; j < N; j++) begin
            if (c % 2 == 0) ref_a_pix[8*j +: 8] = 8'(rpix(c, t - st[c], j));
            else            ref_b_pix[8*j +: 8] = 8'(rpix(c, t - st[c], j));
          end
          if (c % 2 == 0) ref_a_valid = 1; else ref_b_valid = 1;
        end
      @(posedge clk);
      #1;
      if (e_sad.exists(t)) begin
        seen++;
        check({"R3 valid at last-row edge ", tag}, out_valid == 1'b1, out_valid, 1);
        check({"R2 sad ", tag}, int'(out_sad) == e_sad[t], int'(out_sad), e_sad[t]);
        check({"R6 col ", tag}, int'(out_col) == e_col[t], int'(out_col), e_col[t]);
        check({"R6 vofs ", tag}, int'(out_vofs) == e_vofs[t], int'(out_vofs), e_vofs[t]);
      end else begin
        check({"R9 no result ", tag}, out_valid == 1'b0, out_valid, 0);
      end
    end
    ref_a_valid = 0; ref_b_valid = 0;
    check({"R4 result count ", tag}, seen == ncols * CANDS, seen, ncols * CANDS);
  endtask

  task automatic t_reset();
    do_reset();
    repeat (3) begin
      @(posedge clk); #1;
      check("R1 out_valid after release", out_valid == 1'b0, out_valid, 0);
    end
  endtask

  task automatic t_single();
    do_reset();
    ref_mode = 0;
    load_block(0, 3);
    run_cols("R2 one column", 1, 0);
  endtask

  task automatic t_overlap();
    do_reset();
    ref_mode = 0;
    load_block(0, 5);
    run_cols("R7 R5 gapless alternating", 4, 0);
  endtask

  task automatic t_gap();
    do_reset();
    ref_mode = 0;
    load_block(0, 9);
    run_cols("R9 gapped columns", 3, 4);
  endtask

  task automatic t_extreme();
    do_reset();
    ref_mode = 1;
    load_block(1, 0);
    run_cols("R10 max sum", 1, 0);
    check("R10 max value", e_sad[N-1] == N * N * 255, e_sad[N-1], N * N * 255);
    do_reset();
    load_block(2, 0);
    run_cols("R10 zero sum", 1, 0);
  endtask

  task automatic t_load_ignore();
    do_reset();
    ref_mode = 0;
    load_block(0, 7);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      cur_we = 0; cur_row = LG'(k);
      cur_pix = {N{8'hA5 ^ 8'(k * 17)}};
    end
    run_cols("R8 writes disabled", 2, 0);
  endtask

  initial begin
    rst_n = 0;
    idle_inputs();
    ref_mode = 0;
    t_reset();
    t_single();
    t_overlap();
    t_gap();
    t_extreme();
    t_load_ignore();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule